// File: doc/BRIEF.md
# SPI Register and Memory Target with Word Parity

This block is an SPI target that lets an external host read and write a 16-bit byte-addressed space. The low end of that space holds a small byte memory. The top end holds a bank of 16-bit control registers. Every other address is unmapped. A host opens a transaction by pulling chip select low and sends a command byte. It then sends a big-endian start address and streams data bytes. The address steps up by one after each data byte until chip select returns high. Reads place one dummy byte between the address and the first returned byte, so the target has time to fetch.

Two strap pins pick the clock polarity and phase. A parity input switches the target into a framed word mode. In that mode every transfer carries exactly one 16-bit word, and a bit-interleaved parity byte protects it. A write whose parity byte disagrees with the frame is dropped, and the target pulses an error output. SCK, MOSI and chip select are brought into the system clock through synchronisers. The system clock must therefore run well above the SPI bit rate.

Top module: `spi_rm_slave`

## Requirements
- R1: `mode_sel` selects the SPI mode, with bit 1 as CPOL and bit 0 as CPHA (00, 01, 10, 11 = modes 0 to 3). Data is captured and driven on the edges that mode defines, and transfers are correct in all four modes.
- R2: The first byte is the command. 0x02 writes. 0x03 and 0x0B both read and behave the same. Any other value makes the target ignore the rest of the transaction: it writes nothing and returns 0x00 on every byte.
- R3: Bytes 2 and 3 carry address bits 15..8 and then 7..0. On a read, byte 4 is a dummy byte and the first data byte returns as byte 5. MISO returns 0x00 during the command, address and dummy bytes and during every byte of a write.
- R4: Outside parity mode, each data byte moves the address up by one. A burst continues until chip select rises.
- R5: Addresses below MEM_BYTES (0x0000 to 0x003F by default) hit the byte memory. The top 2*REG_WORDS addresses (0xFFF0 to 0xFFFF by default) hit the registers, little-endian, with the low byte at the even address. Writes to any other address are dropped and reads return 0x00.
- R6: Once a burst steps from the range of its start address into another range, every later write in that transaction is dropped. Every later read returns 0x00. Wrapping from 0xFFFF to 0x0000 counts as such a step.
- R7: In parity mode a write frame is command, two address bytes, two data bytes and one parity byte. The parity byte is the bitwise XOR of the two address bytes and the two data bytes; the command byte is not covered. When the parity byte matches, the first data byte goes to the start address and the second to the start address plus one.
- R8: In parity mode a write whose parity byte does not match writes nothing, and `bip_err` goes high for exactly one clock. `bip_err` stays low in every other case.
- R9: In parity mode a read frame returns data at the start address and at the next address as bytes 5 and 6. Byte 7 is the XOR of both address bytes, the dummy byte and the two returned bytes. Any later byte returns 0x00.
- R10: `miso_oe` is low whenever `cs_n` is high and high whenever `cs_n` is low.
- R11: After reset every memory byte and every register reads as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 2 | Strap: {CPOL, CPHA} |
| parity_mode | input | 1 | Framed word mode with parity byte; change only while `cs_n` is high |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | SPI clock |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | Output enable for `miso` |
| bip_err | output | 1 | One-clock pulse on a parity mismatch in a write frame |

## Verification
A wrong bit counter, byte index or mode decode corrupts the first returned byte of a read. It shows up within one byte time after the dummy byte. A wrong address, range or crossing state shows up as a wrong byte in a later read of the same location. The bench therefore reads back every write, usually in the next transaction. A parity accumulator error appears either as a wrong trailing byte on a framed read or as a wrong count of `bip_err` pulses by the time chip select rises.

// File: rtl/spi_rm_pkg.sv
// Shared types and address decode for the SPI register/memory target.
// Assumes the memory range starts at 0 and the register range ends at 0xFFFF.
package spi_rm_pkg;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_WR   = 2'd1,
        CMD_RD   = 2'd2,
        CMD_IGN  = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        RG_MEM  = 2'd0,
        RG_REG  = 2'd1,
        RG_NONE = 2'd2
    } range_e;

    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_FREAD = 8'h0B;

    // Classify a byte address into its range.
    function automatic range_e addr_range(input logic [15:0] a,
                                          input int unsigned mem_bytes,
                                          input int unsigned reg_base);
        int unsigned ua;
        ua = {16'd0, a};
        if (ua < mem_bytes)  return RG_MEM;
        if (ua >= reg_base)  return RG_REG;
        return RG_NONE;
    endfunction

endpackage

// File: rtl/spi_rm_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous inputs.
// Assumes each bit is independent; the bundle is not coherent across bits.
module spi_rm_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        // Shift the input one flop further along the chain.
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[g] <= RST_VAL;
            else if (g == 0) stage_q[g] <= d;
            else stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/spi_rm_edge.sv
// Turns a synchronised SCK into capture and launch strobes for the chosen mode.
// Assumes SCK is already in the clk domain and the mode straps are static.
module spi_rm_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_s,
    input  logic cpol,
    input  logic cpha,
    output logic smp_stb,
    output logic lnc_stb
);
    logic lvl, lvl_d, lead, trail;

    // Normalise polarity so that the leading edge is always a rise.
    assign lvl = sck_s ^ cpol;

    // Remember the previous normalised level.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_d <= 1'b0;
        else        lvl_d <= lvl;
    end

    assign lead    = lvl & ~lvl_d;
    assign trail   = ~lvl & lvl_d;
    assign smp_stb = cpha ? trail : lead;
    assign lnc_stb = cpha ? lead  : trail;
endmodule

// File: rtl/spi_rm_storage.sv
// Byte memory plus a bank of 16-bit little-endian registers, one byte port each way.
// Assumes MEM_BYTES and 2*REG_WORDS are powers of two and REG_WORDS >= 2.
module spi_rm_storage
    import spi_rm_pkg::*;
#(
    parameter int unsigned MEM_BYTES = 64,
    parameter int unsigned REG_WORDS = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  range_e      wr_sel,
    input  logic [15:0] wr_addr,
    input  logic [7:0]  wr_data,
    input  range_e      rd_sel,
    input  logic [15:0] rd_addr,
    output logic [7:0]  rd_data
);
    localparam int unsigned MEM_AW = $clog2(MEM_BYTES);
    localparam int unsigned REG_AW = $clog2(REG_WORDS);

    logic [7:0]  mem_q [MEM_BYTES];
    logic [15:0] reg_q [REG_WORDS];

    // Byte memory write and reset clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++) mem_q[i] <= 8'h00;
        end else if (wr_en && wr_sel == RG_MEM) begin
            mem_q[wr_addr[MEM_AW-1:0]] <= wr_data;
        end
    end

    for (genvar w = 0; w < REG_WORDS; w++) begin : g_reg
        // Byte-lane write into one register; odd address is the high byte.
        always_ff @(posedge clk) begin
            if (!rst_n) reg_q[w] <= 16'h0000;
            else if (wr_en && wr_sel == RG_REG && wr_addr[REG_AW:1] == REG_AW'(w)) begin
                if (wr_addr[0]) reg_q[w][15:8] <= wr_data;
                else            reg_q[w][7:0]  <= wr_data;
            end
        end
    end

    // Read mux across both ranges; unmapped returns zero.
    always_comb begin
        case (rd_sel)
            RG_MEM:  rd_data = mem_q[rd_addr[MEM_AW-1:0]];
            RG_REG:  rd_data = rd_addr[0] ? reg_q[rd_addr[REG_AW:1]][15:8]
                                          : reg_q[rd_addr[REG_AW:1]][7:0];
            default: rd_data = 8'h00;
        endcase
    end
endmodule

// File: rtl/spi_rm_slave.sv
// SPI target: command decode, streaming address, range guard and parity framing.
// Assumes clk runs at least 8x faster than SCK and that parity_mode and
// mode_sel change only while cs_n is high.
module spi_rm_slave
    import spi_rm_pkg::*;
#(
    parameter int unsigned MEM_BYTES   = 64,
    parameter int unsigned REG_WORDS   = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_sel,
    input  logic       parity_mode,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       mosi,
    output logic       miso,
    output logic       miso_oe,
    output logic       bip_err
);
    localparam int unsigned REG_BASE = 32'h1_0000 - 2*REG_WORDS;

    logic        cs_s, sck_s, mosi_s, active;
    logic        edge_smp, edge_lnc, smp_stb, lnc_stb;
    logic [2:0]  bit_cnt, byte_idx;
    logic [7:0]  rx_sr, rx_next, addr_hi, par_q, par_next, tx_q, tx_next;
    logic [7:0]  d0_q, d1_q, st_rd, rd_byte, st_wr_data;
    logic [15:0] addr_q;
    logic [1:0]  commit_cnt;
    logic        byte_done, bip_q, crossed_q, acc_ok, adv, fetch, stream_wr;
    logic        commit_busy, st_wr_en, miso_q, bip_err_q;
    cmd_e        cmd_q;
    range_e      home_q, cur_rng;

    spi_rm_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({cs_n, sck, mosi}), .q({cs_s, sck_s, mosi_s})
    );

    spi_rm_edge u_edge (
        .clk(clk), .rst_n(rst_n), .sck_s(sck_s), .cpol(mode_sel[1]), .cpha(mode_sel[0]),
        .smp_stb(edge_smp), .lnc_stb(edge_lnc)
    );

    assign active  = ~cs_s;
    assign smp_stb = edge_smp & active;
    assign lnc_stb = edge_lnc & active;

    assign rx_next     = {rx_sr[6:0], mosi_s};
    assign byte_done   = smp_stb && (bit_cnt == 3'd7);
    assign cur_rng     = addr_range(addr_q, MEM_BYTES, REG_BASE);
    assign acc_ok      = (cur_rng == home_q) && !crossed_q && (home_q != RG_NONE);
    assign rd_byte     = acc_ok ? st_rd : 8'h00;
    assign commit_busy = (commit_cnt != 2'd0);
    assign fetch       = byte_done && cmd_q == CMD_RD && byte_idx >= 3'd3
                         && (!bip_q || byte_idx <= 3'd4);
    assign stream_wr   = byte_done && cmd_q == CMD_WR && byte_idx >= 3'd3 && !bip_q;
    assign adv         = commit_busy || stream_wr || fetch;
    assign st_wr_en    = (commit_busy || stream_wr) && acc_ok;
    assign st_wr_data  = commit_busy ? ((commit_cnt == 2'd2) ? d0_q : d1_q) : rx_next;

    spi_rm_storage #(.MEM_BYTES(MEM_BYTES), .REG_WORDS(REG_WORDS)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(st_wr_en), .wr_sel(cur_rng), .wr_addr(addr_q), .wr_data(st_wr_data),
        .rd_sel(cur_rng), .rd_addr(addr_q), .rd_data(st_rd)
    );

    // Next parity tally and next transmit byte at a byte boundary.
    always_comb begin
        par_next = par_q;
        tx_next  = 8'h00;
        if (byte_idx == 3'd1 || byte_idx == 3'd2) par_next = par_q ^ rx_next;
        if (cmd_q == CMD_WR && (byte_idx == 3'd3 || byte_idx == 3'd4)) par_next = par_q ^ rx_next;
        if (cmd_q == CMD_RD) begin
            if (byte_idx == 3'd3)      par_next = par_q ^ rx_next ^ rd_byte;
            else if (byte_idx == 3'd4) par_next = par_q ^ rd_byte;
            if (fetch) tx_next = rd_byte;
            else if (bip_q && byte_idx == 3'd5) tx_next = par_q;
        end
    end

    // Bit and byte counting, receive shift register and MISO launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0; byte_idx <= '0; rx_sr <= '0; miso_q <= 1'b0;
            tx_q <= '0; par_q <= '0; bip_q <= 1'b0;
        end else if (!active) begin
            bit_cnt <= '0; byte_idx <= '0; miso_q <= 1'b0;
            tx_q <= '0; par_q <= '0; bip_q <= parity_mode;
        end else begin
            if (lnc_stb) miso_q <= tx_q[3'd7 - bit_cnt];
            if (smp_stb) begin
                rx_sr   <= rx_next;
                bit_cnt <= bit_cnt + 3'd1;
            end
            if (byte_done) begin
                byte_idx <= (byte_idx == 3'd7) ? 3'd7 : byte_idx + 3'd1;
                tx_q     <= tx_next;
                par_q    <= par_next;
            end
        end
    end

    // Command, address, range guard and parity-framed write commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= CMD_NONE; addr_hi <= '0; addr_q <= '0; home_q <= RG_NONE;
            crossed_q <= 1'b0; d0_q <= '0; d1_q <= '0; commit_cnt <= '0; bip_err_q <= 1'b0;
        end else begin
            bip_err_q <= 1'b0;
            if (commit_busy) commit_cnt <= commit_cnt - 2'd1;
            if (adv) begin
                addr_q <= addr_q + 16'd1;
                if (cur_rng != home_q) crossed_q <= 1'b1;
            end
            if (!active) begin
                cmd_q <= CMD_NONE;
            end else if (byte_done) begin
                case (byte_idx)
                    3'd0: begin
                        if (rx_next == OP_WRITE) cmd_q <= CMD_WR;
                        else if (rx_next == OP_READ || rx_next == OP_FREAD) cmd_q <= CMD_RD;
                        else cmd_q <= CMD_IGN;
                    end
                    3'd1: addr_hi <= rx_next;
                    3'd2: begin
                        addr_q    <= {addr_hi, rx_next};
                        home_q    <= addr_range({addr_hi, rx_next}, MEM_BYTES, REG_BASE);
                        crossed_q <= 1'b0;
                    end
                    default: begin
                        if (cmd_q == CMD_WR && bip_q) begin
                            if (byte_idx == 3'd3) d0_q <= rx_next;
                            if (byte_idx == 3'd4) d1_q <= rx_next;
                            if (byte_idx == 3'd5) begin
                                if (rx_next == par_q) commit_cnt <= 2'd2;
                                else                  bip_err_q  <= 1'b1;
                            end
                        end
                    end
                endcase
            end
        end
    end

    assign miso    = miso_q;
    assign miso_oe = ~cs_n;
    assign bip_err = bip_err_q;
endmodule

// File: rtl/spi_rm_chk.sv
// Protocol checker for spi_rm_slave, attached with bind.
module spi_rm_chk
    import spi_rm_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic parity_mode,
    input logic bip_err,
    input logic smp,
    input logic lnc,
    input logic wr_en,
    input cmd_e cmd,
    input logic crossed,
    input logic commit_busy
);
    // R1
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(smp && lnc));
    // R2
    ignored_cmd_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_IGN) |-> !wr_en);
    // R6
    crossed_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crossed |-> !wr_en);
    // R7
    framed_write_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (parity_mode && wr_en) |-> commit_busy);
    // R8
    err_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bip_err |=> !bip_err);
    // R8
    err_needs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bip_err |-> parity_mode);
endmodule

bind spi_rm_slave spi_rm_chk u_chk (
    .clk(clk), .rst_n(rst_n), .parity_mode(parity_mode), .bip_err(bip_err),
    .smp(smp_stb), .lnc(lnc_stb), .wr_en(st_wr_en), .cmd(cmd_q),
    .crossed(crossed_q), .commit_busy(commit_busy)
);

// File: tb/tb_spi_rm_slave.sv
// Bench: behavioural host and byte-level reference model of the address space.
module tb_spi_rm_slave;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic       parity_mode = 1'b0;
    logic       cs_n = 1'b1;
    logic       sck = 1'b0;
    logic       mosi = 1'b0;
    logic       miso, miso_oe, bip_err;

    int n_cmp = 0, n_bad = 0, err_seen = 0;
    bit cpol = 0, cpha = 0;
    logic [7:0] wd [0:7];
    logic [7:0] mdl [int];

    always #5 clk = ~clk;

    spi_rm_slave dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .parity_mode(parity_mode),
        .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso), .miso_oe(miso_oe),
        .bip_err(bip_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // R10: output enable follows chip select, compared every clock
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R10", {31'd0, miso_oe}, {31'd0, ~cs_n});
            if (bip_err) err_seen++;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    function automatic int rng(input logic [15:0] a);
        if (a < 16'h0040) return 0;
        if (a >= 16'hFFF0) return 1;
        return 2;
    endfunction

    function automatic logic [7:0] mget(input logic [15:0] a);
        return mdl.exists(int'(a)) ? mdl[int'(a)] : 8'h00;
    endfunction

    // One model access: returns read data, writes if asked, advances address.
    function automatic logic [7:0] step(inout logic [15:0] cur, inout bit crossed,
                                        input int home, input bit wr, input logic [7:0] d);
        bit ok;
        logic [7:0] r;
        ok = (rng(cur) == home) && !crossed && (home != 2);
        r = ok ? mget(cur) : 8'h00;
        if (ok && wr) mdl[int'(cur)] = d;
        if (rng(cur) != home) crossed = 1;
        cur = cur + 16'd1;
        return r;
    endfunction

    task automatic wait_half();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        mode_sel = m; cpol = m[1]; cpha = m[0]; sck = m[1];
        repeat (8) @(negedge clk);
    endtask

    task automatic shift_byte(input logic [7:0] t, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) begin
            if (!cpha) begin
                mosi = t[i]; wait_half(); sck = ~cpol; r[i] = miso; wait_half(); sck = cpol;
            end else begin
                sck = ~cpol; mosi = t[i]; wait_half(); sck = cpol; r[i] = miso; wait_half();
            end
        end
    endtask

    task automatic xfer(input string tag, input logic [7:0] cmd, input logic [15:0] a,
                        input int n, input bit corrupt);
        logic [7:0] tx [0:15];
        logic [7:0] ex [0:15];
        logic [7:0] rb, p, junk;
        logic [15:0] cur;
        bit crossed, bip;
        int nb, home, exp_err;
        bip = parity_mode; cur = a; crossed = 0; home = rng(a); exp_err = 0;
        for (int j = 0; j < 16; j++) begin tx[j] = 8'h00; ex[j] = 8'h00; end
        tx[0] = cmd; tx[1] = a[15:8]; tx[2] = a[7:0];
        if (cmd == 8'h02 && bip) begin
            nb = 6; tx[3] = wd[0]; tx[4] = wd[1];
            p = a[15:8] ^ a[7:0] ^ wd[0] ^ wd[1];
            tx[5] = p ^ (corrupt ? 8'h10 : 8'h00);
            if (corrupt) exp_err = 1;
            else begin
                junk = step(cur, crossed, home, 1, wd[0]);
                junk = step(cur, crossed, home, 1, wd[1]);
            end
        end else if (cmd == 8'h02) begin
            nb = 3 + n;
            for (int j = 0; j < n; j++) begin
                tx[3+j] = wd[j];
                junk = step(cur, crossed, home, 1, wd[j]);
            end
        end else if (cmd == 8'h03 || cmd == 8'h0B) begin
            tx[3] = 8'hA5;
            nb = bip ? 7 : 4 + n;
            for (int j = 0; j < (bip ? 2 : n); j++) ex[4+j] = step(cur, crossed, home, 0, 8'h00);
            if (bip) ex[6] = a[15:8] ^ a[7:0] ^ 8'hA5 ^ ex[4] ^ ex[5];
        end else begin
            nb = 3 + n;
            for (int j = 0; j < n; j++) tx[3+j] = wd[j];
        end
        err_seen = 0;
        @(negedge clk); cs_n = 1'b0; repeat (8) @(negedge clk);
        for (int j = 0; j < nb; j++) begin
            shift_byte(tx[j], rb);
            chk(tag, {24'd0, rb}, {24'd0, ex[j]});
        end
        wait_half(); cs_n = 1'b1; repeat (4*HALF) @(negedge clk);
        chk("R8", err_seen, exp_err);
    endtask

    initial begin
        repeat (10) @(negedge clk);
        chk("R10", {31'd0, miso_oe}, 32'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R8", {31'd0, bip_err}, 32'd0);

        set_mode(2'b00);
        xfer("R11", 8'h03, 16'h0000, 4, 0);
        xfer("R11", 8'h03, 16'hFFF0, 4, 0);
        wd[0] = 8'h11; wd[1] = 8'h22; wd[2] = 8'h33; wd[3] = 8'h44;
        xfer("R4", 8'h02, 16'h0010, 4, 0);
        xfer("R3", 8'h03, 16'h0010, 4, 0);

        set_mode(2'b01);
        wd[0] = 8'h81; wd[1] = 8'h7E; wd[2] = 8'hC4;
        xfer("R1", 8'h02, 16'h0020, 3, 0);
        xfer("R1", 8'h0B, 16'h0020, 3, 0);
        set_mode(2'b10);
        wd[0] = 8'h5C; wd[1] = 8'hA3;
        xfer("R1", 8'h02, 16'h0024, 2, 0);
        xfer("R2", 8'h0B, 16'h0020, 6, 0);
        set_mode(2'b11);
        wd[0] = 8'hF0; wd[1] = 8'h0F;
        xfer("R1", 8'h02, 16'h0028, 2, 0);
        xfer("R1", 8'h03, 16'h0026, 4, 0);

        set_mode(2'b00);
        wd[0] = 8'h34; wd[1] = 8'h12;
        xfer("R5", 8'h02, 16'hFFF4, 2, 0);
        xfer("R5", 8'h03, 16'hFFF3, 4, 0);
        wd[0] = 8'hEE; wd[1] = 8'hDD;
        xfer("R2", 8'h05, 16'h0010, 2, 0);
        xfer("R2", 8'h03, 16'h0010, 2, 0);
        xfer("R5", 8'h02, 16'h1000, 2, 0);
        xfer("R5", 8'h03, 16'h1000, 2, 0);

        wd[0] = 8'h5A; wd[1] = 8'h5B;
        xfer("R6", 8'h02, 16'h0000, 2, 0);
        wd[0] = 8'h01; wd[1] = 8'h02; wd[2] = 8'h03; wd[3] = 8'h04;
        xfer("R6", 8'h02, 16'hFFFE, 4, 0);
        xfer("R6", 8'h03, 16'hFFFE, 4, 0);
        xfer("R6", 8'h03, 16'h0000, 2, 0);
        wd[0] = 8'h91; wd[1] = 8'h92; wd[2] = 8'h93; wd[3] = 8'h94;
        xfer("R6", 8'h02, 16'h003E, 4, 0);
        xfer("R6", 8'h03, 16'h003E, 4, 0);

        set_mode(2'b11);
        parity_mode = 1'b1;
        repeat (8) @(negedge clk);
        wd[0] = 8'hC3; wd[1] = 8'h3C;
        xfer("R7", 8'h02, 16'h0030, 2, 0);
        xfer("R9", 8'h03, 16'h0030, 2, 0);
        wd[0] = 8'h00; wd[1] = 8'hFF;
        xfer("R8", 8'h02, 16'h0030, 2, 1);
        xfer("R8", 8'h0B, 16'h0030, 2, 0);
        set_mode(2'b00);
        wd[0] = 8'hAB; wd[1] = 8'hCD;
        xfer("R7", 8'h02, 16'hFFF8, 2, 0);
        xfer("R9", 8'h03, 16'hFFF8, 2, 0);
        parity_mode = 1'b0;
        repeat (8) @(negedge clk);
        xfer("R5", 8'h03, 16'hFFF8, 2, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule